// File: doc/BRIEF.md
# Four-Beat Wavefront Multiply-Add Sequencer

This block runs a single vector instruction for a group of 64 work items on a datapath that has only 16 lanes. The lanes share one control path. The group is cut into four quarters of 16 elements. One quarter passes through the lanes on each of four consecutive clocks, so one instruction occupies the datapath for four beats.

Every lane forms A times B plus C on 16-bit signed operands. The lanes read the operands from a small internal vector register array. Each element's result is written back only if its bit in a 64-bit execution mask is set.

Instructions arrive on a valid/ready handshake. While the four beats run, the block refuses further instructions. It flags the fourth beat with a one-cycle done pulse and then takes the next instruction. The register array has a plain write port and a combinational read port. These let the surrounding logic load operands and collect results while the sequencer is idle.

Top module: `wave_issue_seq`

## Requirements
- R1: After reset, in_ready is 1, done is 0, and every element of every vector register reads 0 through rd_data.
- R2: An instruction is taken at a rising edge where in_valid and in_ready are both 1. in_ready then stays 0 for the following four cycles.
- R3: Beat k (k = 0, 1, 2, 3) runs in the k-th cycle after acceptance and writes elements 16k to 16k+15. Element indices are the values on wr_idx and rd_idx. When beat k ends, the elements of quarters above k still hold their old values.
- R4: done is 1 for exactly one cycle, during beat 3. in_ready is 1 in the next cycle, so an instruction held valid from the done cycle is accepted at the next edge.
- R5: Each written element becomes the low 16 bits of A*B+C. A, B and C are that element's values in registers in_src_a, in_src_b and in_src_c, each taken as a 16-bit two's-complement value, and the result wraps modulo 2^16.
- R6: Bit i of in_mask governs element i of register in_dst. An element whose bit is 0 keeps its previous value. An all-zero mask changes nothing.
- R7: A write on wr_en stores wr_data into element wr_idx of register wr_reg at the rising edge, but only when in_ready is 1. While in_ready is 0 the write has no effect. rd_data shows element rd_idx of register rd_reg without delay.
- R8: A destination equal to one of the sources works per element. Each result uses the source value from before the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer idle and able to accept |
| in_dst | input | 2 | Destination vector register |
| in_src_a | input | 2 | Multiplicand register |
| in_src_b | input | 2 | Multiplier register |
| in_src_c | input | 2 | Addend register |
| in_mask | input | 64 | Per-element write enable |
| done | output | 1 | High during the last beat |
| wr_en | input | 1 | Element write strobe |
| wr_reg | input | 2 | Register written |
| wr_idx | input | 6 | Element written |
| wr_data | input | 16 | Write value |
| rd_reg | input | 2 | Register read |
| rd_idx | input | 6 | Element read |
| rd_data | output | 16 | Element value |

## Verification
The multiply-add is driven with several kinds of operand sets. Pseudo-random operands with a full mask cover the general arithmetic. Hand-picked extreme values such as the most negative number times minus one, and maximum values multiplied together, separate a correct wrap from sign-extension or saturation errors. Sentinel values in the destination are read at each intermediate beat, which exposes a wrong quarter order or a wrong beat count. Sparse and all-zero masks, a destination that aliases a source, a write attempted while busy, and an instruction held valid across the done cycle each isolate masking, read-before-write, write blocking and the no-bubble handover.

// File: rtl/wis_pkg.sv
package wis_pkg;

  localparam int WIS_GROUP = 64;
  localparam int WIS_LANES = 16;
  localparam int WIS_DW    = 16;
  localparam int WIS_NREG  = 4;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } wis_state_e;

endpackage

// File: rtl/wis_ctrl.sv
module wis_ctrl #(
  parameter int BEATS = 4,
  parameter int REGW  = 2,
  parameter int GROUP = 64,
  localparam int BW   = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [REGW-1:0]  in_dst,
  input  logic [REGW-1:0]  in_sa,
  input  logic [REGW-1:0]  in_sb,
  input  logic [REGW-1:0]  in_sc,
  input  logic [GROUP-1:0] in_mask,
  output logic             in_ready,
  output logic             done,
  output logic             run,
  output logic [BW-1:0]    beat,
  output logic [REGW-1:0]  q_dst,
  output logic [REGW-1:0]  q_sa,
  output logic [REGW-1:0]  q_sb,
  output logic [REGW-1:0]  q_sc,
  output logic [GROUP-1:0] q_mask
);
  import wis_pkg::*;

  localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

  wis_state_e st_q, st_d;
  logic [BW-1:0] beat_q, beat_d;
  logic          take;

  assign in_ready = (st_q == ST_IDLE);
  assign run      = (st_q == ST_RUN);
  assign beat     = beat_q;
  assign done     = run && (beat_q == LAST);
  assign take     = in_valid && in_ready;

  // next-state
  always_comb begin
    st_d   = st_q;
    beat_d = beat_q;
    case (st_q)
      ST_IDLE: begin
        if (take) begin
          st_d   = ST_RUN;
          beat_d = '0;
        end
      end
      default: begin
        if (beat_q == LAST) begin
          st_d   = ST_IDLE;
          beat_d = '0;
        end else begin
          beat_d = beat_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
    end else begin
      st_q   <= st_d;
      beat_q <= beat_d;
    end
  end

  // instruction hold register, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_dst  <= '0;
      q_sa   <= '0;
      q_sb   <= '0;
      q_sc   <= '0;
      q_mask <= '0;
    end else if (take) begin
      q_dst  <= in_dst;
      q_sa   <= in_sa;
      q_sb   <= in_sb;
      q_sc   <= in_sc;
      q_mask <= in_mask;
    end
  end

  // R2: acceptance closes the handshake at once
  a_r2_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !in_ready);

  // R3: beats advance by one per cycle until the last
  a_r3_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !done) |=> (run && beat == $past(beat) + 1'b1));

  // R4: done lasts one cycle and frees the port right after
  a_r4_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (in_ready && !done));

endmodule

// File: rtl/wis_lane.sv
module wis_lane #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] c,
  output logic [DW-1:0] y
);
  // The low DW bits of a two's-complement product and sum do not depend
  // on sign, so the DW-wide unsigned form gives the wrapped signed result.
  assign y = a * b + c;
endmodule

// File: rtl/wis_regfile.sv
module wis_regfile #(
  parameter int NREG  = 4,
  parameter int GROUP = 64,
  parameter int LANES = 16,
  parameter int DW    = 16,
  localparam int REGW = $clog2(NREG),
  localparam int IDXW = $clog2(GROUP),
  localparam int LW   = $clog2(LANES),
  localparam int BW   = IDXW - LW,
  localparam int AW   = REGW + IDXW,
  localparam int NEL  = NREG * GROUP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bw_en,
  input  logic [BW-1:0]     bw_beat,
  input  logic [REGW-1:0]   bw_dst,
  input  logic [REGW-1:0]   bw_sa,
  input  logic [REGW-1:0]   bw_sb,
  input  logic [REGW-1:0]   bw_sc,
  input  logic [LANES-1:0]  bw_mask,
  input  logic [LANES*DW-1:0] bw_res,
  output logic [LANES*DW-1:0] op_a,
  output logic [LANES*DW-1:0] op_b,
  output logic [LANES*DW-1:0] op_c,
  input  logic              ext_we,
  input  logic [REGW-1:0]   ext_reg,
  input  logic [IDXW-1:0]   ext_idx,
  input  logic [DW-1:0]     ext_wdata,
  input  logic [REGW-1:0]   ext_rreg,
  input  logic [IDXW-1:0]   ext_ridx,
  output logic [DW-1:0]     ext_rdata
);

  logic [DW-1:0] mem_q [NEL];
  logic [DW-1:0] mem_d [NEL];

  // beat-quarter operand reads
  for (genvar l = 0; l < LANES; l++) begin : g_rd
    assign op_a[l*DW +: DW] = mem_q[{bw_sa, bw_beat, LW'(l)}];
    assign op_b[l*DW +: DW] = mem_q[{bw_sb, bw_beat, LW'(l)}];
    assign op_c[l*DW +: DW] = mem_q[{bw_sc, bw_beat, LW'(l)}];
  end

  assign ext_rdata = mem_q[{ext_rreg, ext_ridx}];

  // next-state: beat write-back has priority over the element port
  always_comb begin
    mem_d = mem_q;
    if (bw_en) begin
      for (int l = 0; l < LANES; l++) begin
        if (bw_mask[l]) begin
          mem_d[{bw_dst, bw_beat, LW'(l)}] = bw_res[l*DW +: DW];
        end
      end
    end else if (ext_we) begin
      mem_d[{ext_reg, ext_idx}] = ext_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NEL; i++) mem_q[i] <= '0;
    end else begin
      mem_q <= mem_d;
    end
  end

  // capture of lane 0's target when it is masked off, for the hold check
  logic          chk_arm;
  logic [AW-1:0] chk_addr;
  logic [DW-1:0] chk_old;
  logic [AW-1:0] lane0_addr;

  assign lane0_addr = {bw_dst, bw_beat, LW'(0)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_arm  <= 1'b0;
      chk_addr <= '0;
      chk_old  <= '0;
    end else begin
      chk_arm  <= bw_en && !bw_mask[0];
      chk_addr <= lane0_addr;
      chk_old  <= mem_q[lane0_addr];
    end
  end

  // R6: a masked-off element keeps its value across its beat
  a_r6_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    chk_arm |-> (mem_q[chk_addr] == chk_old));

endmodule

// File: rtl/wave_issue_seq.sv
module wave_issue_seq #(
  parameter int GROUP = wis_pkg::WIS_GROUP,
  parameter int LANES = wis_pkg::WIS_LANES,
  parameter int DW    = wis_pkg::WIS_DW,
  parameter int NREG  = wis_pkg::WIS_NREG
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [$clog2(NREG)-1:0]  in_dst,
  input  logic [$clog2(NREG)-1:0]  in_src_a,
  input  logic [$clog2(NREG)-1:0]  in_src_b,
  input  logic [$clog2(NREG)-1:0]  in_src_c,
  input  logic [GROUP-1:0]         in_mask,
  output logic                     done,
  input  logic                     wr_en,
  input  logic [$clog2(NREG)-1:0]  wr_reg,
  input  logic [$clog2(GROUP)-1:0] wr_idx,
  input  logic [DW-1:0]            wr_data,
  input  logic [$clog2(NREG)-1:0]  rd_reg,
  input  logic [$clog2(GROUP)-1:0] rd_idx,
  output logic [DW-1:0]            rd_data
);

  localparam int BEATS = GROUP / LANES;
  localparam int REGW  = $clog2(NREG);
  localparam int IDXW  = $clog2(GROUP);
  localparam int LW    = $clog2(LANES);
  localparam int BW    = IDXW - LW;

  logic            run;
  logic [BW-1:0]   beat;
  logic [REGW-1:0] q_dst, q_sa, q_sb, q_sc;
  logic [GROUP-1:0] q_mask;
  logic [LANES-1:0] beat_mask;
  logic [LANES*DW-1:0] op_a, op_b, op_c, res;
  logic            ext_we;

  wis_ctrl #(
    .BEATS (BEATS),
    .REGW  (REGW),
    .GROUP (GROUP)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_dst   (in_dst),
    .in_sa    (in_src_a),
    .in_sb    (in_src_b),
    .in_sc    (in_src_c),
    .in_mask  (in_mask),
    .in_ready (in_ready),
    .done     (done),
    .run      (run),
    .beat     (beat),
    .q_dst    (q_dst),
    .q_sa     (q_sa),
    .q_sb     (q_sb),
    .q_sc     (q_sc),
    .q_mask   (q_mask)
  );

  // quarter of the mask that belongs to the current beat
  assign beat_mask = q_mask[{beat, LW'(0)} +: LANES];

  // element port is blocked while an instruction is in flight
  assign ext_we = wr_en && in_ready;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    wis_lane #(.DW(DW)) u_lane (
      .a (op_a[l*DW +: DW]),
      .b (op_b[l*DW +: DW]),
      .c (op_c[l*DW +: DW]),
      .y (res[l*DW +: DW])
    );
  end

  wis_regfile #(
    .NREG  (NREG),
    .GROUP (GROUP),
    .LANES (LANES),
    .DW    (DW)
  ) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .bw_en     (run),
    .bw_beat   (beat),
    .bw_dst    (q_dst),
    .bw_sa     (q_sa),
    .bw_sb     (q_sb),
    .bw_sc     (q_sc),
    .bw_mask   (beat_mask),
    .bw_res    (res),
    .op_a      (op_a),
    .op_b      (op_b),
    .op_c      (op_c),
    .ext_we    (ext_we),
    .ext_reg   (wr_reg),
    .ext_idx   (wr_idx),
    .ext_wdata (wr_data),
    .ext_rreg  (rd_reg),
    .ext_ridx  (rd_idx),
    .ext_rdata (rd_data)
  );

  // R7: a blocked element write leaves the addressed element untouched
  // when the running instruction does not target that register
  a_r7_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_ready && wr_reg != q_dst && rd_reg == wr_reg && rd_idx == wr_idx)
      |=> (rd_data == $past(rd_data) || $past(rd_reg) != rd_reg || $past(rd_idx) != rd_idx));

endmodule

// File: tb/wave_issue_seq_tb.sv
module wave_issue_seq_tb;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [1:0]  in_dst, in_src_a, in_src_b, in_src_c;
  logic [63:0] in_mask;
  logic        done;
  logic        wr_en;
  logic [1:0]  wr_reg;
  logic [5:0]  wr_idx;
  logic [15:0] wr_data;
  logic [1:0]  rd_reg;
  logic [5:0]  rd_idx;
  logic [15:0] rd_data;

  int checks = 0;
  int bad    = 0;
  bit finished = 0;

  logic [15:0] model [4][64];

  wave_issue_seq u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b), .in_src_c(in_src_c),
    .in_mask(in_mask), .done(done), .wr_en(wr_en), .wr_reg(wr_reg), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_reg(rd_reg), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] mac16(input logic [15:0] a, input logic [15:0] b,
                                        input logic [15:0] c);
    int p;
    p = $signed(a) * $signed(b) + $signed(c);
    return p[15:0];
  endfunction

  task automatic peek(input int r, input int i, output logic [15:0] v);
    rd_reg = 2'(r);
    rd_idx = 6'(i);
    #1;
    v = rd_data;
  endtask

  task automatic poke(input int r, input int i, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_reg = 2'(r); wr_idx = 6'(i); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model[r][i] = d;
  endtask

  task automatic load_reg(input int r, input int seed);
    for (int i = 0; i < 64; i++)
      poke(r, i, 16'((i * 40503 + r * 1009 + seed * 4099) ^ (i << 9)));
  endtask

  task automatic cmp_reg(input string tag, input int r);
    logic [15:0] v;
    for (int i = 0; i < 64; i++) begin
      peek(r, i, v);
      chk($sformatf("%s reg%0d[%0d]", tag, r, i), v, model[r][i]);
    end
  endtask

  // Runs one instruction; checks handshake, done timing and optional beat order.
  task automatic issue(input string tag, input int d, input int a, input int b, input int c,
                       input logic [63:0] m, input bit order_chk);
    logic [15:0] nv [64];
    logic [15:0] v;
    for (int i = 0; i < 64; i++)
      nv[i] = m[i] ? mac16(model[a][i], model[b][i], model[c][i]) : model[d][i];
    @(negedge clk);
    in_valid = 1'b1; in_dst = 2'(d); in_src_a = 2'(a); in_src_b = 2'(b); in_src_c = 2'(c);
    in_mask = m;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R2 ready low after accept"}, in_ready, 0);
    chk({tag, " R4 no done in beat0"}, done, 0);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      chk($sformatf("%s R4 done at step %0d", tag, k), done, (k == 3) ? 1 : 0);
      chk($sformatf("%s R2 ready at step %0d", tag, k), in_ready, (k == 4) ? 1 : 0);
      if (order_chk) begin
        peek(d, 16 * (k - 1), v);
        chk($sformatf("R3 quarter %0d written", k - 1), v, nv[16 * (k - 1)]);
        if (k < 4) begin
          peek(d, 16 * k, v);
          chk($sformatf("R3 quarter %0d not yet written", k), v, model[d][16 * k]);
        end
      end
    end
    for (int i = 0; i < 64; i++) model[d][i] = nv[i];
    cmp_reg(tag, d);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    int nz = 0;
    chk("R1 ready after reset", in_ready, 1);
    chk("R1 done after reset", done, 0);
    for (int r = 0; r < 4; r++)
      for (int i = 0; i < 64; i++) begin
        peek(r, i, v);
        if (v != 16'h0) nz++;
      end
    chk("R1 nonzero elements after reset", nz, 0);
  endtask

  task automatic t_basic;
    load_reg(0, 1); load_reg(1, 2); load_reg(2, 3);
    issue("R5 full mask", 3, 0, 1, 2, {64{1'b1}}, 1'b0);
  endtask

  task automatic t_order;
    for (int q = 0; q < 4; q++) poke(3, 16 * q, 16'h7777);
    issue("R3 order", 3, 2, 0, 1, {64{1'b1}}, 1'b1);
  endtask

  task automatic t_mask;
    issue("R6 sparse mask", 3, 1, 2, 0, 64'hF0F0_1234_8000_0001, 1'b0);
    issue("R6 zero mask", 3, 0, 0, 0, 64'h0, 1'b0);
  endtask

  task automatic t_extremes;
    logic [15:0] v;
    poke(0, 0, 16'h7FFF); poke(1, 0, 16'h7FFF); poke(2, 0, 16'h7FFF);
    poke(0, 1, 16'h8000); poke(1, 1, 16'hFFFF); poke(2, 1, 16'h0000);
    poke(0, 2, 16'h8000); poke(1, 2, 16'h8000); poke(2, 2, 16'h0001);
    poke(0, 3, 16'h1234); poke(1, 3, 16'h0000); poke(2, 3, 16'hFFFF);
    issue("R5 extremes", 3, 0, 1, 2, {64{1'b1}}, 1'b0);
    peek(3, 0, v); chk("R5 max*max+max wraps", v, 16'h8000);
    peek(3, 1, v); chk("R5 min*-1 wraps", v, 16'h8000);
    peek(3, 2, v); chk("R5 min*min+1", v, 16'h0001);
    peek(3, 3, v); chk("R5 x*0-1", v, 16'hFFFF);
  endtask

  task automatic t_alias;
    issue("R8 dst aliases src", 0, 0, 1, 0, {64{1'b1}}, 1'b0);
  endtask

  task automatic t_ext_busy;
    logic [15:0] v;
    logic [15:0] old;
    old = model[3][63];
    @(negedge clk);
    in_valid = 1'b1; in_dst = 2'd2; in_src_a = 2'd0; in_src_b = 2'd1; in_src_c = 2'd0;
    in_mask = {64{1'b1}};
    @(negedge clk);
    in_valid = 1'b0;
    wr_en = 1'b1; wr_reg = 2'd3; wr_idx = 6'd63; wr_data = old ^ 16'hABCD;
    @(negedge clk);
    wr_en = 1'b0;
    for (int i = 0; i < 64; i++) model[2][i] = mac16(model[0][i], model[1][i], model[0][i]);
    repeat (4) @(negedge clk);
    peek(3, 63, v);
    chk("R7 write ignored while busy", v, old);
    cmp_reg("R7 busy op result", 2);
    poke(3, 63, 16'h5A5A);
    peek(3, 63, v);
    chk("R7 write taken when idle", v, 16'h5A5A);
  endtask

  task automatic t_b2b;
    logic [15:0] v;
    @(negedge clk);
    in_valid = 1'b1; in_dst = 2'd3; in_src_a = 2'd0; in_src_b = 2'd1; in_src_c = 2'd2;
    in_mask = {64{1'b1}};
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 done before handover", done, 1);
    in_valid = 1'b1; in_dst = 2'd2; in_src_a = 2'd3; in_src_b = 2'd1; in_src_c = 2'd3;
    in_mask = 64'h0F0F_0F0F_FFFF_0000;
    @(negedge clk);
    chk("R4 ready in cycle after done", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R4 second op accepted with no bubble", in_ready, 0);
    for (int i = 0; i < 64; i++) model[3][i] = mac16(model[0][i], model[1][i], model[2][i]);
    for (int i = 0; i < 64; i++)
      if (in_mask[i]) model[2][i] = mac16(model[3][i], model[1][i], model[3][i]);
    repeat (3) @(negedge clk);
    chk("R4 second done", done, 1);
    @(negedge clk);
    chk("R4 ready after second op", in_ready, 1);
    cmp_reg("R4 first op result", 3);
    cmp_reg("R4 second op result", 2);
    peek(2, 0, v);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_dst = '0; in_src_a = '0; in_src_b = '0;
    in_src_c = '0; in_mask = '0; wr_en = 1'b0; wr_reg = '0; wr_idx = '0; wr_data = '0;
    rd_reg = '0; rd_idx = '0;
    for (int r = 0; r < 4; r++) for (int i = 0; i < 64; i++) model[r][i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_order();
    t_mask();
    t_extremes();
    t_alias();
    t_ext_busy();
    t_b2b();
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule